// File: doc/BRIEF.md
# ADC Analog Front-End Power-Up Sequencer

This block brings up the analog front end of an on-chip pipelined converter from a single software enable. When the enable rises, the band-gap and reference supplies switch on together. After a long settling interval the converter core is switched on. After a second, much shorter interval, the block declares itself ready. Both intervals are counted in clock cycles. The counts are derived from a clock-frequency parameter and two wait parameters given in microseconds. The defaults are 8000 µs for the band-gap/reference wait and 50 µs for the core wait.

Conversion requests pass to the converter only while the block is ready. A request that arrives earlier would produce results with too much gain, so it is blocked and latches a sticky error flag, which software clears with a clear pulse. Removing the enable switches every supply off in one step from any state. Enabling again always restarts the full sequence from the band-gap stage.

All pins are plain control and status levels; there is no streaming data path and no back-pressure. The conversion request is sampled as a level on every rising clock edge.

Top module: `adcpu_seq_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, all outputs are low after the clock edge (supplies off, not ready, error flag clear).
- R2: With `pwr_on` high in the off state, `bg_en` and `ref_en` both go high after the next rising edge, in the same cycle, while `core_en` stays low.
- R3: `core_en` rises only after `bg_en`/`ref_en` have been high for exactly BG_CYC = (CLK_HZ/1_000_000)*BG_WAIT_US clock cycles.
- R4: `ready` rises only after `core_en` has been high for exactly CORE_CYC = (CLK_HZ/1_000_000)*CORE_WAIT_US clock cycles.
- R5: `core_en` is never high unless `bg_en` and `ref_en` are both high, and `ready` is never high unless `core_en` is high.
- R6: `conv_start` is `conv_req` AND `ready`, with no clock delay; a request while not ready never reaches `conv_start`.
- R7: A `conv_req` sampled high while `ready` is low sets `early_err` at the next edge, and `early_err` then stays high until cleared.
- R8: `err_clr` sampled high clears `early_err` at the next edge, unless an early request is sampled in the same cycle, in which case the flag stays set.
- R9: `pwr_on` sampled low forces `bg_en`, `ref_en`, `core_en` and `ready` all low at the next edge, from any state.
- R10: After a power-down, raising `pwr_on` again restarts the whole sequence from the band-gap stage with the full BG_CYC wait; a partial sequence never resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on | input | 1 | Software power enable for the front end |
| conv_req | input | 1 | Conversion request, sampled as a level |
| err_clr | input | 1 | Clears the early-request error flag |
| bg_en | output | 1 | Band-gap supply enable, active high |
| ref_en | output | 1 | Reference supply enable, active high |
| core_en | output | 1 | Converter core supply enable, active high |
| ready | output | 1 | Front end settled; conversions allowed |
| conv_start | output | 1 | Gated conversion start |
| early_err | output | 1 | Sticky flag: a request arrived before ready |

## Verification
On every cycle the assertions check several properties. They check the supply ordering and that `ready` implies the core is on. They check that a start never leaks while not ready, and the one-edge shutdown. They check how the error flag is set, how it holds and how it clears. Counters in the checker confirm that each supply was held for its exact cycle count at the moment the next stage turns on. Only the bench scenarios show that an interrupted sequence restarts from the first stage for every possible interruption point. Only they also show the exact cycle of each transition as seen at the pins, and the combinational behaviour of `conv_start` within a cycle.

// File: rtl/adcpu_pkg.sv
package adcpu_pkg;

  typedef enum logic [1:0] {
    PU_OFF   = 2'd0,
    PU_BGREF = 2'd1,
    PU_CORE  = 2'd2,
    PU_READY = 2'd3
  } pu_state_t;

  // Whole clock cycles in a wait given in microseconds.
  function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                input int unsigned wait_us);
    return (clk_hz / 1_000_000) * wait_us;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/adcpu_settle_timer.sv
module adcpu_settle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (expired) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adcpu_seq_fsm.sv
module adcpu_seq_fsm
  import adcpu_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BG_LAST   = 7,
  parameter int unsigned CORE_LAST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_on,
  input  logic             expired,
  output pu_state_t        state,
  output logic             run,
  output logic [CNT_W-1:0] last
);

  localparam logic [CNT_W-1:0] BG_LAST_W   = CNT_W'(BG_LAST);
  localparam logic [CNT_W-1:0] CORE_LAST_W = CNT_W'(CORE_LAST);

  pu_state_t state_q, state_d;

  assign state = state_q;
  assign run   = (state_q == PU_BGREF) || (state_q == PU_CORE);
  assign last  = (state_q == PU_BGREF) ? BG_LAST_W : CORE_LAST_W;

  always_comb begin
    state_d = state_q;
    if (!pwr_on) begin
      state_d = PU_OFF;
    end else begin
      unique case (state_q)
        PU_OFF:   state_d = PU_BGREF;
        PU_BGREF: if (expired) state_d = PU_CORE;
        PU_CORE:  if (expired) state_d = PU_READY;
        PU_READY: state_d = PU_READY;
        default:  state_d = PU_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PU_OFF;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/adcpu_early_flag.sv
module adcpu_early_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;

  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/adcpu_seq_top.sv
module adcpu_seq_top
  import adcpu_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned BG_WAIT_US   = 8000,
  parameter int unsigned CORE_WAIT_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  input  logic conv_req,
  input  logic err_clr,
  output logic bg_en,
  output logic ref_en,
  output logic core_en,
  output logic ready,
  output logic conv_start,
  output logic early_err
);

  localparam int unsigned BG_CYC   = settle_cycles(CLK_HZ, BG_WAIT_US);
  localparam int unsigned CORE_CYC = settle_cycles(CLK_HZ, CORE_WAIT_US);
  localparam int unsigned MAX_CYC  = (BG_CYC > CORE_CYC) ? BG_CYC : CORE_CYC;
  localparam int unsigned CNT_W    = cnt_width(MAX_CYC);

  pu_state_t        state;
  logic             run;
  logic             expired;
  logic [CNT_W-1:0] last;

  adcpu_seq_fsm #(
    .CNT_W    (CNT_W),
    .BG_LAST  (BG_CYC - 1),
    .CORE_LAST(CORE_CYC - 1)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .pwr_on (pwr_on),
    .expired(expired),
    .state  (state),
    .run    (run),
    .last   (last)
  );

  adcpu_settle_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (!pwr_on),
    .run    (run),
    .last   (last),
    .expired(expired)
  );

  assign bg_en      = (state != PU_OFF);
  assign ref_en     = (state != PU_OFF);
  assign core_en    = (state == PU_CORE) || (state == PU_READY);
  assign ready      = (state == PU_READY);
  assign conv_start = conv_req && ready;

  adcpu_early_flag u_flag (
    .clk (clk),
    .rst (rst),
    .set (conv_req && !ready),
    .clr (err_clr),
    .flag(early_err)
  );

endmodule

// File: rtl/adcpu_seq_checker.sv
module adcpu_seq_checker
  import adcpu_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned BG_WAIT_US   = 8000,
  parameter int unsigned CORE_WAIT_US = 50
) (
  input logic clk,
  input logic rst,
  input logic pwr_on,
  input logic conv_req,
  input logic err_clr,
  input logic bg_en,
  input logic ref_en,
  input logic core_en,
  input logic ready,
  input logic conv_start,
  input logic early_err
);

  localparam int unsigned BG_CYC   = settle_cycles(CLK_HZ, BG_WAIT_US);
  localparam int unsigned CORE_CYC = settle_cycles(CLK_HZ, CORE_WAIT_US);

  int unsigned bg_held, core_held;

  always_ff @(posedge clk) begin
    if (rst || !bg_en)            bg_held <= 0;
    else if (bg_held != BG_CYC)   bg_held <= bg_held + 1;
    if (rst || !core_en)          core_held <= 0;
    else if (core_held != CORE_CYC) core_held <= core_held + 1;
  end

  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> !bg_en && !ref_en && !core_en && !ready && !early_err);

  p_bg_ref_pair_r2: assert property (@(posedge clk) disable iff (rst)
    bg_en == ref_en);

  p_core_wait_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en) |-> bg_held == BG_CYC);

  p_ready_wait_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> core_held == CORE_CYC);

  p_core_order_r5: assert property (@(posedge clk) disable iff (rst)
    core_en |-> bg_en && ref_en);

  p_ready_core_r5: assert property (@(posedge clk) disable iff (rst)
    ready |-> core_en);

  p_start_gated_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ready && conv_req);

  p_early_set_r7: assert property (@(posedge clk) disable iff (rst)
    conv_req && !ready |=> early_err);

  p_early_hold_r7: assert property (@(posedge clk) disable iff (rst)
    early_err && !err_clr |=> early_err);

  p_early_clear_r8: assert property (@(posedge clk) disable iff (rst)
    err_clr && !(conv_req && !ready) |=> !early_err);

  p_shutdown_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> !bg_en && !ref_en && !core_en && !ready);

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(bg_en) |-> !core_en && !ready);

endmodule

bind adcpu_seq_top adcpu_seq_checker #(
  .CLK_HZ      (CLK_HZ),
  .BG_WAIT_US  (BG_WAIT_US),
  .CORE_WAIT_US(CORE_WAIT_US)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_on    (pwr_on),
  .conv_req  (conv_req),
  .err_clr   (err_clr),
  .bg_en     (bg_en),
  .ref_en    (ref_en),
  .core_en   (core_en),
  .ready     (ready),
  .conv_start(conv_start),
  .early_err (early_err)
);

// File: tb/test_adcpu_seq_top.sv
module test_adcpu_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 1_000_000;
  localparam int T_BG_US    = 5;
  localparam int T_CORE_US  = 3;
  localparam int BG         = (T_CLK_HZ / 1_000_000) * T_BG_US;
  localparam int CORE       = (T_CLK_HZ / 1_000_000) * T_CORE_US;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst, pwr_on, conv_req, err_clr;
  logic bg_en, ref_en, core_en, ready, conv_start, early_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adcpu_seq_top #(
    .CLK_HZ      (T_CLK_HZ),
    .BG_WAIT_US  (T_BG_US),
    .CORE_WAIT_US(T_CORE_US)
  ) i_adcpu_seq_top (
    .clk       (clk),
    .rst       (rst),
    .pwr_on    (pwr_on),
    .conv_req  (conv_req),
    .err_clr   (err_clr),
    .bg_en     (bg_en),
    .ref_en    (ref_en),
    .core_en   (core_en),
    .ready     (ready),
    .conv_start(conv_start),
    .early_err (early_err)
  );

  // Expected {bg,ref,core,ready} after n rising edges with the enable held.
  function automatic logic [3:0] expect_pwr(input int n);
    if (n <= 0)         return 4'b0000;
    if (n <= BG)        return 4'b1100;
    if (n <= BG + CORE) return 4'b1110;
    return 4'b1111;
  endfunction

  function automatic string stage_tag(input int n);
    if (n == 1)          return "R2";
    if (n <= BG + 1)     return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pwr_vec();
    return {bg_en, ref_en, core_en, ready};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; pwr_on = 1'b0; conv_req = 1'b0; err_clr = 1'b0;
    repeat (3) step();
    check("R1 reset outputs", {pwr_vec(), 1'b0, early_err, conv_start},
          7'b0);
    rst = 1'b0;

    // Full power-up sweep, every cycle checked.
    pwr_on = 1'b1;
    for (int n = 1; n <= BG + CORE + 3; n++) begin
      step();
      check(stage_tag(n), pwr_vec(), expect_pwr(n));
      if (core_en) check("R5 core needs bg/ref", {bg_en, ref_en}, 2'b11);
      check("R7 no spurious error", {3'b0, early_err}, 4'b0);
    end

    // Request while ready passes straight through, no error.
    conv_req = 1'b1;
    #1 check("R6 start while ready", {3'b0, conv_start}, 4'b0001);
    step();
    check("R7 no error when ready", {3'b0, early_err}, 4'b0);
    conv_req = 1'b0;
    #1 check("R6 start follows request", {3'b0, conv_start}, 4'b0);

    // Single-step shutdown from READY.
    @(negedge clk);
    pwr_on = 1'b0;
    step();
    check("R9 shutdown from ready", pwr_vec(), 4'b0000);

    // Early request blocked and latched.
    conv_req = 1'b1;
    #1 check("R6 blocked when not ready", {3'b0, conv_start}, 4'b0);
    step();
    conv_req = 1'b0;
    check("R7 early error set", {3'b0, early_err}, 4'b0001);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R7 early error sticky", {3'b0, early_err}, 4'b0001);
    end
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    check("R8 clear", {3'b0, early_err}, 4'b0);

    // Simultaneous clear and early request: set wins.
    err_clr = 1'b1; conv_req = 1'b1;
    step();
    err_clr = 1'b0; conv_req = 1'b0;
    check("R8 set wins over clear", {3'b0, early_err}, 4'b0001);
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    check("R8 clear after set", {3'b0, early_err}, 4'b0);

    // Interrupt at every point, then demand a full restart.
    for (int d = 1; d <= BG + CORE + 2; d++) begin
      pwr_on = 1'b1;
      repeat (d) step();
      pwr_on = 1'b0;
      step();
      check("R9 shutdown mid-sequence", pwr_vec(), 4'b0000);
      pwr_on = 1'b1;
      for (int n = 1; n <= BG + CORE + 1; n++) begin
        step();
        check("R10 restart from band-gap", pwr_vec(), expect_pwr(n));
      end
      pwr_on = 1'b0;
      step();
    end

    // Reset mid-sequence returns everything low.
    pwr_on = 1'b1;
    repeat (BG + 2) step();
    rst = 1'b1;
    step();
    check("R1 reset mid-sequence", pwr_vec(), 4'b0000);
    rst = 1'b0;
    pwr_on = 1'b0;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule